// File: doc/BRIEF.md
# Wrapping Stack Pointer Unit

This unit owns the stack pointer of a small 8-bit controller core and turns stack requests into accesses on a simple synchronous byte memory port. The stack occupies a fixed window between a floor and a ceiling address. The pointer never leaves that window. Stepping down past the floor lands on the ceiling, and stepping up past the ceiling lands on the floor. Writes use the current pointer and then move it down. Reads move the pointer up first and then use the new value.

The core issues one command code per cycle. Single-byte push and pull, 16-bit return-address push and pull, and five-byte interrupt frame save and restore all go through one sequencer. The sequencer issues one memory access per cycle. It reports busy while a sequence runs and pulses done when the sequence ends. Two further commands act on the pointer at once: a stack reset, and a reload from an external value. A mode input picks between a small low-memory window and a larger window higher up. Pulled bytes land in result registers that the core reads once done is seen.

Top module: `stack_window_unit`

## Requirements
- R1: Command code 1 writes `push_byte` at the current pointer and then lowers the pointer by one. If the lowered value would be below the floor, the pointer becomes the ceiling.
- R2: Command code 2 raises the pointer by one and then reads the byte at the new pointer into `pop_byte`. If the raised value would exceed the ceiling, the pointer becomes the floor.
- R3: Command code 3 writes `pc_in[7:0]` at the pointer and then `pc_in[15:8]` one address lower. Command code 4 reads the high byte first and then the low byte, and presents the pair on `pop_pc`.
- R4: With `ext_mode` = 0 the window runs from floor 0x060 to ceiling 0x07F. With `ext_mode` = 1 it runs from floor 0x100 to ceiling 0x17F.
- R5: A cycle with `rst` high sets the pointer to the ceiling of the window that `ext_mode` selects. It also clears `busy`, `done`, `mem_we` and `mem_re`.
- R6: Command code 7 sets the pointer to the ceiling. Command code 8 sets it to (`load_val` AND ceiling) OR floor. Either new value shows on `sp` in the cycle after the command.
- R7: Command code 5 saves an interrupt frame. It makes five writes at descending addresses, in this order: PC low byte, PC high byte, `x_in`, `a_in`, `cc_in`.
- R8: Command code 6 restores a frame. It makes five reads at ascending addresses, in this order: condition codes, A, X, PC high byte, PC low byte. The results go to `pop_cc`, `pop_a`, `pop_x` and `pop_pc`.
- R9: `busy` stays high while a sequence runs. `done` is high for exactly one cycle at the end, and `busy` is low in that cycle. A command that arrives while busy is ignored. Code 0 and codes 9 to 15 are also ignored: they start no access and leave the pointer unchanged.
- R10: `mem_addr` is the pointer zero-extended to 16 bits. Read data on `mem_rdata` is taken one cycle after the cycle in which `mem_re` is high. The pulled results are valid when `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_mode | input | 1 | Window select: 0 selects the low window, 1 the high window |
| cmd | input | 4 | Command code, sampled when the unit is not busy |
| push_byte | input | 8 | Data for a single-byte push |
| pc_in | input | 16 | Return address for a word push or a frame save |
| x_in | input | 8 | Index register value for a frame save |
| a_in | input | 8 | Accumulator value for a frame save |
| cc_in | input | 8 | Condition-code value for a frame save |
| load_val | input | 9 | Value for a pointer reload |
| mem_rdata | input | 8 | Read data from the stack memory |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| sp | output | 9 | Current stack pointer |
| pop_byte | output | 8 | Result of a single-byte pull |
| pop_pc | output | 16 | Result of a word pull or frame restore |
| pop_x | output | 8 | Restored index register |
| pop_a | output | 8 | Restored accumulator |
| pop_cc | output | 8 | Restored condition codes |

## Verification
Two things can happen in the same cycle and must be tested together. The first is a pointer wrap and a frame beat. The second is a new command and a sequence that is still running. For the first, the bench loads the pointer two steps above the floor of the high window and then saves a frame, so the write sequence crosses the floor partway through. Restoring that frame crosses the ceiling in the other direction. The bench checks every byte address and the final pointer against the window rules. For the second, the bench presents a push and then a reload during the cycles just after a frame save starts. It judges the result at the ports: the number of writes, the final pointer and the done pulse must all match a frame save with no extra command.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [3:0] {
    OP_NONE     = 4'd0,
    OP_PUSH_B   = 4'd1,
    OP_PULL_B   = 4'd2,
    OP_PUSH_W   = 4'd3,
    OP_PULL_W   = 4'd4,
    OP_PUSH_INT = 4'd5,
    OP_PULL_INT = 4'd6,
    OP_SP_RESET = 4'd7,
    OP_SP_LOAD  = 4'd8
  } stk_op_e;

  typedef enum logic [2:0] {
    DST_BYTE,
    DST_PCH,
    DST_PCL,
    DST_X,
    DST_A,
    DST_CC
  } stk_dst_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_DRAIN1,
    ST_DRAIN2
  } stk_state_e;

  function automatic logic op_is_push(input stk_op_e op);
    return (op == OP_PUSH_B) || (op == OP_PUSH_W) || (op == OP_PUSH_INT);
  endfunction

  function automatic logic op_is_seq(input stk_op_e op);
    return (op == OP_PUSH_B) || (op == OP_PULL_B) || (op == OP_PUSH_W) ||
           (op == OP_PULL_W) || (op == OP_PUSH_INT) || (op == OP_PULL_INT);
  endfunction

  // Index of the final beat of a sequence
  function automatic logic [2:0] op_last_beat(input stk_op_e op);
    case (op)
      OP_PUSH_W, OP_PULL_W:     return 3'd1;
      OP_PUSH_INT, OP_PULL_INT: return 3'd4;
      default:                  return 3'd0;
    endcase
  endfunction

  // Where the byte read on a given pull beat is stored
  function automatic stk_dst_e pull_dst(input stk_op_e op, input logic [2:0] beat);
    case (op)
      OP_PULL_W: return (beat == 3'd0) ? DST_PCH : DST_PCL;
      OP_PULL_INT: begin
        case (beat)
          3'd0:    return DST_CC;
          3'd1:    return DST_A;
          3'd2:    return DST_X;
          3'd3:    return DST_PCH;
          default: return DST_PCL;
        endcase
      end
      default: return DST_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/stk_window_sel.sv
module stk_window_sel #(
  parameter int SP_W = 9,
  parameter logic [SP_W-1:0] LO_FLOOR = 9'h060,
  parameter logic [SP_W-1:0] LO_CEIL  = 9'h07F,
  parameter logic [SP_W-1:0] HI_FLOOR = 9'h100,
  parameter logic [SP_W-1:0] HI_CEIL  = 9'h17F
) (
  input  logic            ext_mode,
  output logic [SP_W-1:0] floor_o,
  output logic [SP_W-1:0] ceil_o
);
  assign floor_o = ext_mode ? HI_FLOOR : LO_FLOOR;
  assign ceil_o  = ext_mode ? HI_CEIL  : LO_CEIL;
endmodule

// File: rtl/stk_wrap_calc.sv
module stk_wrap_calc #(
  parameter int SP_W = 9
) (
  input  logic [SP_W-1:0] sp_i,
  input  logic [SP_W-1:0] floor_i,
  input  logic [SP_W-1:0] ceil_i,
  input  logic [SP_W-1:0] load_i,
  output logic [SP_W-1:0] sp_down_o,
  output logic [SP_W-1:0] sp_up_o,
  output logic [SP_W-1:0] sp_norm_o
);
  // Stepping below the floor (including from zero) lands on the ceiling
  assign sp_down_o = (sp_i <= floor_i) ? ceil_i : (sp_i - 1'b1);
  // Stepping above the ceiling lands on the floor
  assign sp_up_o   = (sp_i >= ceil_i) ? floor_i : (sp_i + 1'b1);
  // Forced reload value folded into the window
  assign sp_norm_o = (load_i & ceil_i) | floor_i;
endmodule

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
  import stk_pkg::*;
#(
  parameter int SP_W   = 9,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        cmd,
  input  logic [DATA_W-1:0] push_byte,
  input  logic [2*DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] cc_in,
  input  logic [SP_W-1:0]   ceil_i,
  input  logic [SP_W-1:0]   floor_i,
  input  logic [SP_W-1:0]   sp_down_i,
  input  logic [SP_W-1:0]   sp_up_i,
  input  logic [SP_W-1:0]   sp_norm_i,
  output logic [SP_W-1:0]   sp_o,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output stk_dst_e          rd_dst,
  output logic              busy,
  output logic              done
);
  localparam int PAD = ADDR_W - SP_W;

  stk_state_e         st;
  stk_op_e            op_q;
  stk_op_e            op_in;
  logic [2:0]         beat;
  logic [DATA_W-1:0]  byte_q, x_q, a_q, cc_q;
  logic [2*DATA_W-1:0] pc_q;
  logic [DATA_W-1:0]  wdata_nxt;
  logic               last_beat;

  assign op_in     = stk_op_e'(cmd);
  assign last_beat = (beat == op_last_beat(op_q));
  assign busy      = (st != ST_IDLE);

  always_comb begin
    case (op_q)
      OP_PUSH_W:   wdata_nxt = (beat == 3'd0) ? pc_q[DATA_W-1:0] : pc_q[2*DATA_W-1:DATA_W];
      OP_PUSH_INT: begin
        case (beat)
          3'd0:    wdata_nxt = pc_q[DATA_W-1:0];
          3'd1:    wdata_nxt = pc_q[2*DATA_W-1:DATA_W];
          3'd2:    wdata_nxt = x_q;
          3'd3:    wdata_nxt = a_q;
          default: wdata_nxt = cc_q;
        endcase
      end
      default:     wdata_nxt = byte_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      op_q      <= OP_NONE;
      beat      <= 3'd0;
      sp_o      <= ceil_i;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      rd_dst    <= DST_BYTE;
      done      <= 1'b0;
      byte_q    <= '0;
      x_q       <= '0;
      a_q       <= '0;
      cc_q      <= '0;
      pc_q      <= '0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      done   <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (op_is_seq(op_in)) begin
            op_q   <= op_in;
            beat   <= 3'd0;
            byte_q <= push_byte;
            pc_q   <= pc_in;
            x_q    <= x_in;
            a_q    <= a_in;
            cc_q   <= cc_in;
            st     <= ST_ISSUE;
          end else if (op_in == OP_SP_RESET) begin
            sp_o <= ceil_i;
          end else if (op_in == OP_SP_LOAD) begin
            sp_o <= sp_norm_i;
          end
        end
        ST_ISSUE: begin
          if (op_is_push(op_q)) begin
            mem_we    <= 1'b1;
            mem_addr  <= {{PAD{1'b0}}, sp_o};
            mem_wdata <= wdata_nxt;
            sp_o      <= sp_down_i;
          end else begin
            mem_re    <= 1'b1;
            mem_addr  <= {{PAD{1'b0}}, sp_up_i};
            rd_dst    <= pull_dst(op_q, beat);
            sp_o      <= sp_up_i;
          end
          if (last_beat) begin
            if (op_is_push(op_q)) begin
              done <= 1'b1;
              st   <= ST_IDLE;
            end else begin
              st   <= ST_DRAIN1;
            end
          end else begin
            beat <= beat + 3'd1;
          end
        end
        ST_DRAIN1: st <= ST_DRAIN2;
        default: begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end

  AST_PUSH_POSTDEC: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (sp_o == ((mem_addr[SP_W-1:0] <= floor_i) ? ceil_i : (mem_addr[SP_W-1:0] - 1'b1)))); // R1
  AST_PULL_PREINC: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> (sp_o == mem_addr[SP_W-1:0])); // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_re); // R9
endmodule

// File: rtl/stk_pull_cap.sv
module stk_pull_cap
  import stk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mem_re,
  input  stk_dst_e            rd_dst,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [DATA_W-1:0]   pop_byte,
  output logic [2*DATA_W-1:0] pop_pc,
  output logic [DATA_W-1:0]   pop_x,
  output logic [DATA_W-1:0]   pop_a,
  output logic [DATA_W-1:0]   pop_cc
);
  logic     cap_v;
  stk_dst_e cap_dst;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_v    <= 1'b0;
      cap_dst  <= DST_BYTE;
      pop_byte <= '0;
      pop_pc   <= '0;
      pop_x    <= '0;
      pop_a    <= '0;
      pop_cc   <= '0;
    end else begin
      cap_v   <= mem_re;
      cap_dst <= rd_dst;
      if (cap_v) begin
        case (cap_dst)
          DST_PCH: pop_pc[2*DATA_W-1:DATA_W] <= mem_rdata;
          DST_PCL: pop_pc[DATA_W-1:0]        <= mem_rdata;
          DST_X:   pop_x                     <= mem_rdata;
          DST_A:   pop_a                     <= mem_rdata;
          DST_CC:  pop_cc                    <= mem_rdata;
          default: pop_byte                  <= mem_rdata;
        endcase
      end
    end
  end

  AST_CAPTURE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (rst)
    cap_v |-> $past(mem_re)); // R10
endmodule

// File: rtl/stack_window_unit.sv
module stack_window_unit
  import stk_pkg::*;
#(
  parameter int SP_W   = 9,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [SP_W-1:0] LO_FLOOR = 9'h060,
  parameter logic [SP_W-1:0] LO_CEIL  = 9'h07F,
  parameter logic [SP_W-1:0] HI_FLOOR = 9'h100,
  parameter logic [SP_W-1:0] HI_CEIL  = 9'h17F
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ext_mode,
  input  logic [3:0]          cmd,
  input  logic [DATA_W-1:0]   push_byte,
  input  logic [2*DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0]   x_in,
  input  logic [DATA_W-1:0]   a_in,
  input  logic [DATA_W-1:0]   cc_in,
  input  logic [SP_W-1:0]     load_val,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic                mem_re,
  output logic                busy,
  output logic                done,
  output logic [SP_W-1:0]     sp,
  output logic [DATA_W-1:0]   pop_byte,
  output logic [2*DATA_W-1:0] pop_pc,
  output logic [DATA_W-1:0]   pop_x,
  output logic [DATA_W-1:0]   pop_a,
  output logic [DATA_W-1:0]   pop_cc
);
  logic [SP_W-1:0] win_floor, win_ceil;
  logic [SP_W-1:0] sp_down, sp_up, sp_norm;
  stk_dst_e        rd_dst;

  stk_window_sel #(
    .SP_W(SP_W), .LO_FLOOR(LO_FLOOR), .LO_CEIL(LO_CEIL),
    .HI_FLOOR(HI_FLOOR), .HI_CEIL(HI_CEIL)
  ) u_win (
    .ext_mode (ext_mode),
    .floor_o  (win_floor),
    .ceil_o   (win_ceil)
  );

  stk_wrap_calc #(.SP_W(SP_W)) u_wrap (
    .sp_i      (sp),
    .floor_i   (win_floor),
    .ceil_i    (win_ceil),
    .load_i    (load_val),
    .sp_down_o (sp_down),
    .sp_up_o   (sp_up),
    .sp_norm_o (sp_norm)
  );

  stk_seq_ctrl #(.SP_W(SP_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .push_byte (push_byte),
    .pc_in     (pc_in),
    .x_in      (x_in),
    .a_in      (a_in),
    .cc_in     (cc_in),
    .ceil_i    (win_ceil),
    .floor_i   (win_floor),
    .sp_down_i (sp_down),
    .sp_up_i   (sp_up),
    .sp_norm_i (sp_norm),
    .sp_o      (sp),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .rd_dst    (rd_dst),
    .busy      (busy),
    .done      (done)
  );

  stk_pull_cap #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .mem_re    (mem_re),
    .rd_dst    (rd_dst),
    .mem_rdata (mem_rdata),
    .pop_byte  (pop_byte),
    .pop_pc    (pop_pc),
    .pop_x     (pop_x),
    .pop_a     (pop_a),
    .pop_cc    (pop_cc)
  );

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re)); // R10
endmodule

// File: tb/stack_window_unit_bench.sv
`timescale 1ns/1ps
module stack_window_unit_bench;
  logic        clk = 1'b0;
  logic        rst, ext_mode;
  logic [3:0]  cmd;
  logic [7:0]  push_byte, x_in, a_in, cc_in, mem_rdata, mem_wdata;
  logic [15:0] pc_in, mem_addr, pop_pc;
  logic [8:0]  load_val, sp;
  logic        mem_we, mem_re, busy, done;
  logic [7:0]  pop_byte, pop_x, pop_a, pop_cc;

  int n_checks = 0;
  int n_err = 0;
  int wr_cnt = 0;
  logic [15:0] last_waddr = 16'h0;
  logic [7:0] mem [0:511];

  always #2 clk = ~clk;

  stack_window_unit u_stack_window_unit (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .cmd(cmd), .push_byte(push_byte),
    .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .cc_in(cc_in), .load_val(load_val),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .busy(busy), .done(done), .sp(sp),
    .pop_byte(pop_byte), .pop_pc(pop_pc), .pop_x(pop_x), .pop_a(pop_a), .pop_cc(pop_cc)
  );

  // Synchronous memory model: data appears one cycle after the read strobe
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr[8:0]] <= mem_wdata;
      wr_cnt     <= wr_cnt + 1;
      last_waddr <= mem_addr;
    end
    if (mem_re) mem_rdata <= mem[mem_addr[8:0]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Caller is at a negedge; command is held for one cycle
  task automatic issue(input logic [3:0] c);
    cmd = c;
    @(negedge clk);
    cmd = 4'd0;
  endtask

  task automatic wait_done(input string req);
    bit seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1;
        break;
      end
    end
    chk({req, " done seen"}, seen, 1);
    chk({req, " busy low with done"}, busy, 0);
    @(negedge clk);
    chk({req, " done lasts one cycle"}, done, 0);
  endtask

  task automatic do_reset(input logic mode);
    ext_mode = mode;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_base;
    chk("R5 sp at ceiling", sp, 9'h07F);
    chk("R5 busy clear", busy, 0);
    chk("R5 done clear", done, 0);
    chk("R5 strobes clear", {mem_we, mem_re}, 2'b00);
  endtask

  task automatic t_byte;
    push_byte = 8'hA5;
    issue(4'd1);
    wait_done("R1 push");
    chk("R1 data at old pointer", mem[9'h07F], 8'hA5);
    chk("R1 pointer lowered", sp, 9'h07E);
    chk("R10 zero-extended address", last_waddr, 16'h007F);
    issue(4'd2);
    wait_done("R2 pull");
    chk("R2 pulled byte", pop_byte, 8'hA5);
    chk("R2 pointer raised", sp, 9'h07F);
  endtask

  task automatic t_wrap;
    load_val = 9'h060;
    issue(4'd8);
    chk("R6 load at floor", sp, 9'h060);
    push_byte = 8'h3C;
    issue(4'd1);
    wait_done("R1 wrap push");
    chk("R1 wrap write at floor", mem[9'h060], 8'h3C);
    chk("R1 below floor becomes ceiling", sp, 9'h07F);
    issue(4'd2);
    wait_done("R2 wrap pull");
    chk("R2 above ceiling becomes floor", sp, 9'h060);
    chk("R2 wrap pull data", pop_byte, 8'h3C);
  endtask

  task automatic t_word;
    issue(4'd7);
    chk("R6 stack reset to ceiling", sp, 9'h07F);
    pc_in = 16'h1234;
    issue(4'd3);
    wait_done("R3 word push");
    chk("R3 low byte first", mem[9'h07F], 8'h34);
    chk("R3 high byte second", mem[9'h07E], 8'h12);
    chk("R3 pointer after word push", sp, 9'h07D);
    pc_in = 16'h0;
    issue(4'd4);
    wait_done("R3 word pull");
    chk("R3 word reassembled", pop_pc, 16'h1234);
    chk("R3 pointer after word pull", sp, 9'h07F);
  endtask

  task automatic t_load_norm;
    load_val = 9'h1A5;
    issue(4'd8);
    chk("R6 reload folded into low window", sp, 9'h065);
    issue(4'd7);
    chk("R6 stack reset after reload", sp, 9'h07F);
  endtask

  task automatic t_frame;
    pc_in = 16'hBEEF; x_in = 8'h11; a_in = 8'h22; cc_in = 8'h0A;
    issue(4'd5);
    chk("R9 busy during frame", busy, 1);
    wait_done("R7 frame save");
    chk("R7 PC low", mem[9'h07F], 8'hEF);
    chk("R7 PC high", mem[9'h07E], 8'hBE);
    chk("R7 X", mem[9'h07D], 8'h11);
    chk("R7 A", mem[9'h07C], 8'h22);
    chk("R7 CC", mem[9'h07B], 8'h0A);
    chk("R7 pointer after save", sp, 9'h07A);
    issue(4'd6);
    wait_done("R8 frame restore");
    chk("R8 CC", pop_cc, 8'h0A);
    chk("R8 A", pop_a, 8'h22);
    chk("R8 X", pop_x, 8'h11);
    chk("R8 PC", pop_pc, 16'hBEEF);
    chk("R8 pointer after restore", sp, 9'h07F);
  endtask

  task automatic t_busy_ignore;
    int w0;
    w0 = wr_cnt;
    pc_in = 16'h4455; x_in = 8'h66; a_in = 8'h77; cc_in = 8'h01;
    issue(4'd5);
    push_byte = 8'hEE;
    issue(4'd1);
    load_val = 9'h060;
    issue(4'd8);
    wait_done("R9 busy frame");
    chk("R9 only frame writes", wr_cnt - w0, 5);
    chk("R9 pointer unaffected by ignored commands", sp, 9'h07A);
    chk("R9 CC slot not overwritten", mem[9'h07B], 8'h01);
    issue(4'd6);
    wait_done("R9 cleanup restore");
    chk("R9 pointer back at ceiling", sp, 9'h07F);
  endtask

  task automatic t_bad_code;
    int w0;
    w0 = wr_cnt;
    issue(4'd9);
    issue(4'd15);
    issue(4'd0);
    @(negedge clk);
    chk("R9 undefined codes leave pointer", sp, 9'h07F);
    chk("R9 undefined codes start nothing", {busy, done}, 2'b00);
    chk("R9 undefined codes write nothing", wr_cnt - w0, 0);
  endtask

  task automatic t_ext;
    do_reset(1'b1);
    chk("R5 high window reset", sp, 9'h17F);
    load_val = 9'h0A5;
    issue(4'd8);
    chk("R4 reload folded into high window", sp, 9'h125);
    load_val = 9'h102;
    issue(4'd8);
    chk("R6 reload near floor", sp, 9'h102);
    pc_in = 16'hCAFE; x_in = 8'h5A; a_in = 8'hA5; cc_in = 8'h03;
    issue(4'd5);
    wait_done("R7 high frame save");
    chk("R4 PC low at 0x102", mem[9'h102], 8'hFE);
    chk("R4 PC high at 0x101", mem[9'h101], 8'hCA);
    chk("R4 X at floor", mem[9'h100], 8'h5A);
    chk("R4 A wrapped to ceiling", mem[9'h17F], 8'hA5);
    chk("R4 CC below ceiling", mem[9'h17E], 8'h03);
    chk("R10 last address zero-extended", last_waddr, 16'h017E);
    chk("R1 pointer after wrapped save", sp, 9'h17D);
    issue(4'd6);
    wait_done("R8 high frame restore");
    chk("R8 CC after wrap", pop_cc, 8'h03);
    chk("R8 A after wrap", pop_a, 8'hA5);
    chk("R8 X after wrap", pop_x, 8'h5A);
    chk("R8 PC after wrap", pop_pc, 16'hCAFE);
    chk("R2 pointer after wrapped restore", sp, 9'h102);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    cmd = 4'd0; push_byte = 8'h0; pc_in = 16'h0; x_in = 8'h0; a_in = 8'h0;
    cc_in = 8'h0; load_val = 9'h0; ext_mode = 1'b0; rst = 1'b1;
    @(negedge clk);
    do_reset(1'b0);
    t_reset_base();
    t_byte();
    t_wrap();
    t_word();
    t_load_norm();
    t_frame();
    t_busy_ignore();
    t_bad_code();
    t_ext();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule